// File: doc/BRIEF.md
# Fixed and Variable Barrel Shifter

This block is the shift unit of a 32-bit integer datapath. In a single pass it can shift an operand left or right by 0 to 31 places. A right shift can fill with zeros or copy the sign bit. The unit can also rotate the operand in either direction. The shift count comes from one of two places: a 5-bit count field carried with the operation, or a second register operand.

The shift network itself is combinational. Its output is captured in a result register. Each accepted request gives exactly one result, one clock later, and a valid flag marks that result for one cycle. When no request is present, the last result stays on the output.

Top module: `shifter_unit`

## Requirements
- R1: Op code 0 (logical left) moves the operand toward bit 31 by the count and fills the freed low bits with zeros.
- R2: Op code 1 (logical right) moves the operand toward bit 0 by the count and fills the freed high bits with zeros; for example 0xFFFFFFF8 by 2 gives 0x3FFFFFFE.
- R3: Op code 2 (arithmetic right) moves the operand toward bit 0 and fills the freed high bits with copies of operand bit 31; for example 0xFFFFFFF8 by 2 gives 0xFFFFFFFE.
- R4: Op code 3 (rotate right) moves the operand toward bit 0, and the bits that leave at bit 0 come back in at bit 31.
- R5: Op code 4 (rotate left) moves the operand toward bit 31, and the bits that leave at bit 31 come back in at bit 0.
- R6: When `amtSel` is 0 the count is `immAmt`. When `amtSel` is 1 the count is `regAmt[4:0]`, and bits 31:5 of `regAmt` have no effect.
- R7: A count of 0 returns the operand unchanged for every op code.
- R8: Op codes 5, 6 and 7 return the operand unchanged, whatever the count.
- R9: A request with `inValid` high in one clock cycle makes `result` and `outValid` take effect after that cycle's rising edge. `outValid` is high for exactly the cycles that follow a request.
- R10: While `inValid` is low, `result` keeps its last value, even if the operand inputs change.
- R11: While `rstN` is low, `outValid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A request is present this cycle |
| opCode | input | 3 | 0 sll, 1 srl, 2 sra, 3 ror, 4 rol, 5-7 pass |
| amtSel | input | 1 | 0: count from immAmt, 1: count from regAmt |
| immAmt | input | 5 | Count field carried with the operation |
| regAmt | input | 32 | Register-supplied count; only bits 4:0 are used |
| operand | input | 32 | Value to shift or rotate |
| outValid | output | 1 | Result is new this cycle |
| result | output | 32 | Registered shift result |

## Verification
Two things can happen in the same cycle: the register presents the result of one request, and it accepts the next request. The bench provokes this by driving a rotate and then a left shift in consecutive cycles. It checks that `outValid` stays high across both results, that each result matches its own operation, and that the result is held once the stream stops. The table loop separately exercises count selection, sign fill and wrap-around at counts 0, 1 and 31.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  parameter int DATA_W = 32;
  parameter int AMT_W  = $clog2(DATA_W);
  parameter int OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SLL = 3'd0,
    OP_SRL = 3'd1,
    OP_SRA = 3'd2,
    OP_ROR = 3'd3,
    OP_ROL = 3'd4
  } shiftOpT;

  // Strobes from control to datapath
  typedef struct packed {
    logic             mirror;    // bit-reverse around the right-moving network
    logic             rotate;    // wrap bits instead of filling
    logic             signFill;  // fill with operand msb
    logic [AMT_W-1:0] amount;    // effective count
    logic             load;      // capture into result register
  } shiftCtrlT;

endpackage

// File: rtl/shifter_ctrl.sv
module shifter_ctrl
  import shifter_pkg::*;
#(
  parameter int WIDTH = DATA_W,
  parameter int AW    = AMT_W
) (
  input  logic            inValid,
  input  logic [OP_W-1:0] opCode,
  input  logic            amtSel,
  input  logic [AW-1:0]   immAmt,
  input  logic [WIDTH-1:0] regAmt,
  output shiftCtrlT       ctrl
);

  logic [AW-1:0] pickedAmt;

  always_comb begin
    pickedAmt = amtSel ? regAmt[AW-1:0] : immAmt;
  end

  always_comb begin
    ctrl          = '0;
    ctrl.load     = inValid;
    ctrl.amount   = pickedAmt;
    case (opCode)
      OP_SLL: ctrl.mirror = 1'b1;
      OP_SRL: ctrl.mirror = 1'b0;
      OP_SRA: ctrl.signFill = 1'b1;
      OP_ROR: ctrl.rotate = 1'b1;
      OP_ROL: begin
        ctrl.rotate = 1'b1;
        ctrl.mirror = 1'b1;
      end
      default: ctrl.amount = '0;
    endcase
  end

endmodule

// File: rtl/shifter_datapath.sv
module shifter_datapath
  import shifter_pkg::*;
#(
  parameter int WIDTH = DATA_W,
  parameter int AW    = AMT_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  shiftCtrlT        ctrl,
  input  logic [WIDTH-1:0] operand,
  output logic             outValid,
  output logic [WIDTH-1:0] result
);

  logic [WIDTH-1:0] stage [0:AW];
  logic [WIDTH-1:0] mirrored;
  logic [WIDTH-1:0] netOut;
  logic             fillBit;

  function automatic logic [WIDTH-1:0] reverseBits(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) r[i] = v[WIDTH-1-i];
    return r;
  endfunction

  always_comb begin
    mirrored = reverseBits(operand);
    stage[0] = ctrl.mirror ? mirrored : operand;
    fillBit  = ctrl.signFill & operand[WIDTH-1];
  end

  for (genvar k = 0; k < AW; k++) begin : gStage
    localparam int SH = 1 << k;
    logic [SH-1:0] entering;
    always_comb begin
      entering     = ctrl.rotate ? stage[k][SH-1:0] : {SH{fillBit}};
      stage[k+1]   = ctrl.amount[k] ? {entering, stage[k][WIDTH-1:SH]} : stage[k];
    end
  end

  always_comb begin
    netOut = ctrl.mirror ? reverseBits(stage[AW]) : stage[AW];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) result <= netOut;
    end
  end

endmodule

// File: rtl/shifter_unit.sv
module shifter_unit
  import shifter_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic              amtSel,
  input  logic [AMT_W-1:0]  immAmt,
  input  logic [DATA_W-1:0] regAmt,
  input  logic [DATA_W-1:0] operand,
  output logic              outValid,
  output logic [DATA_W-1:0] result
);

  shiftCtrlT ctrl;

  shifter_ctrl #(.WIDTH(DATA_W), .AW(AMT_W)) ctrl_i (
    .inValid (inValid),
    .opCode  (opCode),
    .amtSel  (amtSel),
    .immAmt  (immAmt),
    .regAmt  (regAmt),
    .ctrl    (ctrl)
  );

  shifter_datapath #(.WIDTH(DATA_W), .AW(AMT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .operand  (operand),
    .outValid (outValid),
    .result   (result)
  );

endmodule

// File: rtl/shifter_unit_chk.sv
module shifter_unit_chk
  import shifter_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OP_W-1:0]   opCode,
  input logic              amtSel,
  input logic [AMT_W-1:0]  immAmt,
  input logic [DATA_W-1:0] regAmt,
  input logic [DATA_W-1:0] operand,
  input logic              outValid,
  input logic [DATA_W-1:0] result
);

  logic [AMT_W-1:0] effAmt;
  assign effAmt = amtSel ? regAmt[AMT_W-1:0] : immAmt;

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result)); // R10
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && effAmt == '0) |=> result == $past(operand)); // R7
  AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode > 3'd4) |=> result == $past(operand)); // R8
  AST_SLL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 3'd0 && effAmt != '0) |=> !result[0]); // R1
  AST_SRL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 3'd1 && effAmt != '0) |=> !result[DATA_W-1]); // R2
  AST_SRA_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 3'd2) |=> result[DATA_W-1] == $past(operand[DATA_W-1])); // R3
  AST_ROR_POPCOUNT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 3'd3) |=> $countones(result) == $countones($past(operand))); // R4
  AST_ROL_POPCOUNT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode == 3'd4) |=> $countones(result) == $countones($past(operand))); // R5

endmodule

bind shifter_unit shifter_unit_chk chk_i (.*);

// File: tb/shifter_unit_tb_top.sv
module shifter_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic        amtSel = 1'b0;
  logic [4:0]  immAmt = '0;
  logic [31:0] regAmt = '0;
  logic [31:0] operand = '0;
  logic        outValid;
  logic [31:0] result;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  shifter_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .amtSel(amtSel), .immAmt(immAmt), .regAmt(regAmt), .operand(operand),
    .outValid(outValid), .result(result)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic        sel;
    logic [4:0]  imm;
    logic [31:0] rg;
    logic [31:0] opnd;
    logic [31:0] expect_;
    logic [3:0]  req;
  } vecT;

  localparam int NV = 18;
  localparam vecT VECS [NV] = '{
    '{3'd0, 1'b0, 5'd3,  32'h0,        32'h00000077, 32'h000003B8, 4'd1},  // R1
    '{3'd0, 1'b0, 5'd31, 32'h0,        32'h00000001, 32'h80000000, 4'd1},  // R1
    '{3'd1, 1'b0, 5'd2,  32'h0,        32'hFFFFFFF8, 32'h3FFFFFFE, 4'd2},  // R2
    '{3'd1, 1'b0, 5'd31, 32'h0,        32'h80000000, 32'h00000001, 4'd2},  // R2
    '{3'd2, 1'b0, 5'd2,  32'h0,        32'hFFFFFFF8, 32'hFFFFFFFE, 4'd3},  // R3
    '{3'd2, 1'b0, 5'd31, 32'h0,        32'h80000000, 32'hFFFFFFFF, 4'd3},  // R3
    '{3'd2, 1'b0, 5'd4,  32'h0,        32'h7000000F, 32'h07000000, 4'd3},  // R3
    '{3'd3, 1'b0, 5'd1,  32'h0,        32'h00000002, 32'h00000001, 4'd4},  // R4
    '{3'd3, 1'b0, 5'd1,  32'h0,        32'h00000001, 32'h80000000, 4'd4},  // R4
    '{3'd3, 1'b0, 5'd8,  32'h0,        32'h12345678, 32'h78123456, 4'd4},  // R4
    '{3'd4, 1'b0, 5'd4,  32'h0,        32'h80000001, 32'h00000018, 4'd5},  // R5
    '{3'd4, 1'b0, 5'd31, 32'h0,        32'h00000001, 32'h80000000, 4'd5},  // R5
    '{3'd0, 1'b1, 5'd7,  32'hFFFFFFE3, 32'h00000077, 32'h000003B8, 4'd6},  // R6
    '{3'd0, 1'b0, 5'd3,  32'h00000005, 32'h00000077, 32'h000003B8, 4'd6},  // R6
    '{3'd1, 1'b1, 5'd1,  32'h00000020, 32'hF0F0F0F0, 32'hF0F0F0F0, 4'd6},  // R6 low bits zero
    '{3'd2, 1'b0, 5'd0,  32'h0,        32'h80000000, 32'h80000000, 4'd7},  // R7
    '{3'd4, 1'b1, 5'd9,  32'h00000000, 32'hDEADBEEF, 32'hDEADBEEF, 4'd7},  // R7
    '{3'd5, 1'b0, 5'd4,  32'h0,        32'h12345678, 32'h12345678, 4'd8}   // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic sel, input logic [4:0] imm,
                       input logic [31:0] rg, input logic [31:0] opnd);
    @(negedge clk);
    inValid = 1'b1; opCode = op; amtSel = sel; immAmt = imm; regAmt = rg; operand = opnd;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 outValid in reset", {31'b0, outValid}, 32'd0);
    check("R11 result in reset", result, 32'd0);
    rstN = 1'b1;

    // table loop: R1..R8 plus R9 pulse
    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].sel, VECS[i].imm, VECS[i].rg, VECS[i].opnd);
      @(negedge clk);
      inValid = 1'b0;
      check($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].expect_);
      check("R9 outValid after request", {31'b0, outValid}, 32'd1);
    end

    // R9 single pulse and R10 hold while idle with changing inputs
    @(negedge clk);
    check("R9 outValid drops", {31'b0, outValid}, 32'd0);
    operand = 32'hAAAA5555; opCode = 3'd0; immAmt = 5'd1;
    @(negedge clk);
    check("R10 result held", result, 32'h12345678);
    check("R10 outValid idle", {31'b0, outValid}, 32'd0);

    // R9 back-to-back: rotate then left shift in consecutive cycles
    issue(3'd3, 1'b0, 5'd4, 32'h0, 32'h0000000F);
    issue(3'd0, 1'b1, 5'd0, 32'h00000044, 32'h00000003);
    @(negedge clk);
    inValid = 1'b0;
    // sampled one negedge after first request edge happened at the second issue's negedge
    check("R4 back-to-back second result (R1 shift by 4)", result, 32'h00000030);
    check("R9 outValid still high", {31'b0, outValid}, 32'd1);
    @(negedge clk);
    check("R9 outValid low after stream", {31'b0, outValid}, 32'd0);
    check("R10 result held after stream", result, 32'h00000030);

    // R9 first of the pair observed separately
    issue(3'd3, 1'b0, 5'd4, 32'h0, 32'h0000000F);
    @(negedge clk);
    inValid = 1'b0;
    check("R4 rotate right by 4", result, 32'hF0000000);

    // R11 reset mid-run clears outputs
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("R11 result after reset", result, 32'd0);
    check("R11 outValid after reset", {31'b0, outValid}, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule